// File: doc/BRIEF.md
# Parallel Flash Device Bus Front End

This block is the pin-side logic of a parallel NOR-style flash device. It samples the asynchronous bus pins with an internal clock and keeps one address latch. The latch is transparent while latch enable is low. It freezes on the first rising edge of chip enable, latch enable or write enable within an access. When a write cycle completes, the block captures the data word and presents the address and data to the command interpreter as a single-cycle strobe.

On the read side, the block picks what drives the data bus. The source is array data, the information word (identifier, protection or query data, chosen by the interpreter) or the status byte. The status byte takes over whenever the program/erase controller reports busy. In all other cases the bus is switched off.

The reset/power-down pin has four effects. It aborts an operation in progress and clears the status register. It forces the read mode back to array reads. It inhibits writes until a post-release delay has run out.

The array, the program/erase algorithm and the decoding of command codes sit outside the block. A busy flag, data inputs and a mode-load port connect it to them.

Top module: `flash_bus_front`

## Requirements
- R1: `dq_oe` is low, and `dq_out` is all zeros, whenever the synchronized chip enable is high, the synchronized output enable is high or the synchronized reset pin is low. With all three pins in their active state, `dq_oe` is high two clock edges after the last of them changes.
- R2: The read source follows the mode register, which is loaded from `mode_sel` in the cycle `mode_ld` is high. The encodings are: 0 array data, 1 information word, 2 status byte zero-extended, 3 array data.
- R3: While `pe_busy` is high and the bus is driven, `dq_out` carries `status_in` on bits 7:0 and zeros on bits 31:8, whatever the mode.
- R4: While latch enable is low and no access has frozen the latch, `rd_addr` follows `addr_pin` three edges later. A rising latch enable freezes it until latch enable falls again.
- R5: In a write cycle, the address is taken at the first rising edge among chip enable, latch enable and write enable. Later edges in the same cycle, and address changes after that first edge, do not alter it.
- R6: A write cycle ends at the first rise of write enable or chip enable while both were low. It then raises `cmd_valid` for exactly one cycle, three edges after that pin rise, with the captured `cmd_addr` and `cmd_data`.
- R7: With `bus32` low (16-bit bus), address bit 0 selects the half-word: 1 means bits 31:16, 0 means bits 15:0. Reads return the selected half on bits 15:0 and writes keep only `dq_in[15:0]`. With `bus32` high, address bit 0 is forced to 0 in `rd_addr` and `cmd_addr`.
- R8: While the reset pin is low, `status_clr` is high, the mode register returns to array reads and no write strobe is produced.
- R9: `abort_op` pulses for one cycle when the synchronized reset pin falls while `pe_busy` is high. A fall with `pe_busy` low gives no pulse.
- R10: After the reset pin rises, `ready` stays low and completed write cycles are dropped for WR_DELAY cycles. After that, `ready` is high whenever `pe_busy` is low and writes are accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Power-on reset of the internal flops, active low |
| ce_n | input | 1 | Chip enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| le_n | input | 1 | Latch enable pin, active low (latch transparent when low) |
| pd_n | input | 1 | Reset/power-down pin, active low |
| bus32 | input | 1 | Static bus width strap: 1 for 32-bit, 0 for 16-bit |
| addr_pin | input | AW | Address pins, word address |
| dq_in | input | DW | Data pins, input side |
| dq_out | output | DW | Data pins, output side |
| dq_oe | output | 1 | Output driver enable for the data pins |
| rd_addr | output | AW | Latched address toward the array |
| array_data | input | DW | Array read data |
| info_data | input | DW | Identifier, protection or query word |
| status_in | input | 8 | Status register byte |
| pe_busy | input | 1 | Program/erase controller busy |
| mode_ld | input | 1 | Load strobe for the read mode |
| mode_sel | input | 2 | Read mode value to load |
| rd_mode | output | 2 | Current read mode |
| cmd_valid | output | 1 | One-cycle write strobe |
| cmd_addr | output | AW | Address captured with the write |
| cmd_data | output | DW | Data captured with the write |
| status_clr | output | 1 | Status clear, high while reset pin is low |
| abort_op | output | 1 | One-cycle abort of the running operation |
| ready | output | 1 | Ready/busy indication, high when ready |

## Verification
Every pin passes through two flops, so bus enables and combinational read data settle two edges after a pin change. The latched address settles after three edges, and the write strobe comes exactly three edges after the completing pin rise. The stimulus tasks drive pins on falling clock edges and note the cycle number at which each write completes. They queue the expected strobe for that cycle plus three, and the monitor compares the strobe cycle, address and data when the pulse appears. Read, latch and reset checks wait a fixed number of cycles that is at least the latency above before sampling, and the post-release window is probed both inside and after the WR_DELAY interval.

// File: rtl/flash_bus_front.sv
module flash_bus_front #(
  parameter int AW = 22,
  parameter int DW = 32,
  parameter int WR_DELAY = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          le_n,
  input  logic          pd_n,
  input  logic          bus32,
  input  logic [AW-1:0] addr_pin,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] array_data,
  input  logic [DW-1:0] info_data,
  input  logic [7:0]    status_in,
  input  logic          pe_busy,
  input  logic          mode_ld,
  input  logic [1:0]    mode_sel,
  output logic [1:0]    rd_mode,
  output logic          cmd_valid,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic          status_clr,
  output logic          abort_op,
  output logic          ready
);
  localparam int HW = DW / 2;
  localparam int CW = $clog2(WR_DELAY + 1);
  localparam logic [4:0] PIN_IDLE = 5'b01111;
  localparam logic [1:0] M_INFO = 2'd1;
  localparam logic [1:0] M_STAT = 2'd2;

  logic [4:0]    c_m, c_s, c_d;
  logic [AW-1:0] a_m, a_s;
  logic [DW-1:0] d_m, d_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_m <= PIN_IDLE;
      c_s <= PIN_IDLE;
      c_d <= PIN_IDLE;
      a_m <= '0;
      a_s <= '0;
      d_m <= '0;
      d_s <= '0;
    end else begin
      c_m <= {pd_n, le_n, oe_n, we_n, ce_n};
      c_s <= c_m;
      c_d <= c_s;
      a_m <= addr_pin;
      a_s <= a_m;
      d_m <= dq_in;
      d_s <= d_m;
    end
  end

  wire ce_s = c_s[0];
  wire we_s = c_s[1];
  wire oe_s = c_s[2];
  wire le_s = c_s[3];
  wire pd_s = c_s[4];
  wire ce_d = c_d[0];
  wire we_d = c_d[1];
  wire le_d = c_d[3];
  wire pd_d = c_d[4];

  wire any_rise = (ce_s & ~ce_d) | (we_s & ~we_d) | (le_s & ~le_d);
  wire wr_end   = ~ce_d & ~we_d & (ce_s | we_s);
  wire idle     = ce_s & we_s & ~le_s;

  logic [AW-1:0] alat;
  logic          afrz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alat <= '0;
      afrz <= 1'b0;
    end else if (!pd_s) begin
      afrz <= 1'b0;
    end else if (!afrz && any_rise) begin
      alat <= a_s;
      afrz <= 1'b1;
    end else if (afrz && idle) begin
      afrz <= 1'b0;
    end else if (!afrz && !le_s) begin
      alat <= a_s;
    end
  end

  logic [CW-1:0] hold_cnt;
  wire wr_ok = (hold_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hold_cnt <= CW'(WR_DELAY);
    else if (!pd_s)          hold_cnt <= CW'(WR_DELAY);
    else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
  end

  wire [AW-1:0] wr_addr = afrz ? alat : a_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
      abort_op  <= 1'b0;
      rd_mode   <= '0;
    end else begin
      cmd_valid <= wr_end & pd_s & wr_ok;
      if (wr_end) begin
        cmd_addr <= {wr_addr[AW-1:1], wr_addr[0] & ~bus32};
        cmd_data <= bus32 ? d_s : {{(DW-HW){1'b0}}, d_s[HW-1:0]};
      end
      abort_op <= pd_d & ~pd_s & pe_busy;
      if (!pd_s)        rd_mode <= '0;
      else if (mode_ld) rd_mode <= mode_sel;
    end
  end

  wire [DW-1:0] stat_word = {{(DW-8){1'b0}}, status_in};
  wire [DW-1:0] src = (rd_mode == M_INFO) ? info_data :
                      (rd_mode == M_STAT) ? stat_word : array_data;
  wire [DW-1:0] lane = bus32 ? src :
                       {{(DW-HW){1'b0}}, alat[0] ? src[DW-1:HW] : src[HW-1:0]};

  assign rd_addr    = {alat[AW-1:1], alat[0] & ~bus32};
  assign dq_oe      = pd_s & ~ce_s & ~oe_s;
  assign dq_out     = !dq_oe ? '0 : (pe_busy ? stat_word : lane);
  assign status_clr = ~pd_s;
  assign ready      = pd_s & wr_ok & ~pe_busy;
endmodule

// File: rtl/flash_bus_front_chk.sv
module flash_bus_front_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pd_s,
  input logic          pe_busy,
  input logic          bus32,
  input logic          cmd_valid,
  input logic          cmd_addr0,
  input logic          abort_op,
  input logic          ready,
  input logic          dq_oe,
  input logic [DW-1:0] dq_out,
  input logic [7:0]    status_in
);
  // R1
  bus_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_out == '0));

  // R3
  busy_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && pe_busy) |-> (dq_out[DW-1:8] == '0 && dq_out[7:0] == status_in));

  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R7
  wide_addr_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && bus32) |-> !cmd_addr0);

  // R8
  pd_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_s |=> !cmd_valid);

  // R9
  abort_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_op |-> $past(pe_busy));

  // R9
  abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_op |=> !abort_op);

  // R10
  holdoff_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_s) |-> !ready);
endmodule

bind flash_bus_front flash_bus_front_chk #(.DW(DW)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .pd_s(pd_s),
  .pe_busy(pe_busy),
  .bus32(bus32),
  .cmd_valid(cmd_valid),
  .cmd_addr0(cmd_addr[0]),
  .abort_op(abort_op),
  .ready(ready),
  .dq_oe(dq_oe),
  .dq_out(dq_out),
  .status_in(status_in)
);

// File: tb/flash_bus_front_bench.sv
`timescale 1ns/1ps
module flash_bus_front_bench;
  localparam int AW = 22;
  localparam int DW = 32;
  localparam int WD = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, ce_n, oe_n, we_n, le_n, pd_n, bus32, pe_busy, mode_ld;
  logic [AW-1:0] addr_pin, rd_addr, cmd_addr;
  logic [DW-1:0] dq_in, dq_out, array_data, info_data, cmd_data;
  logic [7:0] status_in;
  logic [1:0] mode_sel, rd_mode;
  logic dq_oe, cmd_valid, status_clr, abort_op, ready;

  flash_bus_front #(.AW(AW), .DW(DW), .WR_DELAY(WD)) u_flash_bus_front (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .le_n(le_n), .pd_n(pd_n), .bus32(bus32), .addr_pin(addr_pin),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .rd_addr(rd_addr),
    .array_data(array_data), .info_data(info_data), .status_in(status_in),
    .pe_busy(pe_busy), .mode_ld(mode_ld), .mode_sel(mode_sel),
    .rd_mode(rd_mode), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .status_clr(status_clr), .abort_op(abort_op),
    .ready(ready)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  int aborts = 0;
  bit done = 0;

  int            q_cyc[$];
  logic [AW-1:0] q_addr[$];
  logic [DW-1:0] q_data[$];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    q_cyc.push_back(cyc + 3);
    q_addr.push_back(a);
    q_data.push_back(d);
  endtask

  always @(negedge clk) begin
    if (rst_n && abort_op) aborts++;
    if (rst_n && cmd_valid) begin
      checks++;
      if (q_cyc.size() == 0) begin
        errors++;
        $display("FAIL R6/R10: actual unexpected strobe addr %h data %h expected none",
                 cmd_addr, cmd_data);
      end else begin
        int ec;
        logic [AW-1:0] ea;
        logic [DW-1:0] ed;
        ec = q_cyc.pop_front();
        ea = q_addr.pop_front();
        ed = q_data.pop_front();
        if (ec != cyc || ea !== cmd_addr || ed !== cmd_data) begin
          errors++;
          $display("FAIL R6: actual cyc %0d addr %h data %h expected cyc %0d addr %h data %h",
                   cyc, cmd_addr, cmd_data, ec, ea, ed);
        end
      end
    end
  end

  // write closed by write enable; expect=1 queues the strobe
  task automatic wr_we(input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [AW-1:0] ea, input logic [DW-1:0] ed, input bit expect_it);
    addr_pin = a; dq_in = d; ce_n = 0; we_n = 0;
    step(3);
    we_n = 1;
    if (expect_it) expect_wr(ea, ed);
    step(4);
    ce_n = 1;
    step(5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ce_n = 1; oe_n = 1; we_n = 1; le_n = 0; pd_n = 1; bus32 = 1;
    pe_busy = 0; mode_ld = 0; mode_sel = 0; addr_pin = '0; dq_in = '0;
    array_data = 32'h1122_3344; info_data = 32'h5566_7788; status_in = 8'h80;
    step(2);
    // reset state (R8, R1, R6)
    chk("R8 reset status_clr", status_clr, 1);
    chk("R1 reset dq_oe", dq_oe, 0);
    chk("R6 reset cmd_valid", cmd_valid, 0);
    rst_n = 1;
    step(WD + 6);
    chk("R10 ready after holdoff", ready, 1);

    // R4 transparent latch and freeze
    addr_pin = 22'h00_0A10;
    step(4);
    chk("R4 transparent", rd_addr, 22'h00_0A10);
    le_n = 1;
    step(4);
    addr_pin = 22'h00_0B20;
    step(5);
    chk("R4 frozen", rd_addr, 22'h00_0A10);
    le_n = 0;
    step(6);
    chk("R4 transparent again", rd_addr, 22'h00_0B20);

    // R6 write by write enable, x32 (R7 bit 0 dropped)
    wr_we(22'h01_2345, 32'hCAFE_F00D, 22'h01_2344, 32'hCAFE_F00D, 1);

    // R5 address change after first edge is ignored
    addr_pin = 22'h00_0100; dq_in = 32'h0000_00A5; ce_n = 0; we_n = 0;
    step(3);
    we_n = 1;
    expect_wr(22'h00_0100, 32'h0000_00A5);
    step(4);
    addr_pin = 22'h00_0200;
    step(4);
    chk("R5 held after first edge", rd_addr, 22'h00_0100);
    ce_n = 1;
    step(6);
    chk("R5 released at idle", rd_addr, 22'h00_0200);

    // R6 write closed by chip enable
    addr_pin = 22'h00_0310; dq_in = 32'h1357_9BDF; we_n = 0; ce_n = 0;
    step(3);
    ce_n = 1;
    expect_wr(22'h00_0310, 32'h1357_9BDF);
    step(4);
    we_n = 1;
    step(5);

    // R7 16-bit write keeps bit 0 and low half
    bus32 = 0;
    wr_we(22'h00_0421, 32'hABCD_1234, 22'h00_0421, 32'h0000_1234, 1);

    // R2 reads per mode, x32
    bus32 = 1;
    addr_pin = 22'h00_0040; ce_n = 0; oe_n = 0;
    step(5);
    chk("R1 bus driven", dq_oe, 1);
    chk("R2 array mode", dq_out, 32'h1122_3344);
    mode_sel = 1; mode_ld = 1; step(1); mode_ld = 0; step(1);
    chk("R2 info mode", dq_out, 32'h5566_7788);
    mode_sel = 2; mode_ld = 1; step(1); mode_ld = 0; step(1);
    chk("R2 status mode", dq_out, 32'h0000_0080);
    mode_sel = 3; mode_ld = 1; step(1); mode_ld = 0; step(1);
    chk("R2 mode 3 array", dq_out, 32'h1122_3344);
    mode_sel = 0; mode_ld = 1; step(1); mode_ld = 0; step(1);

    // R7 half-word select
    bus32 = 0;
    addr_pin = 22'h00_0041;
    step(5);
    chk("R7 upper half", dq_out, 32'h0000_1122);
    addr_pin = 22'h00_0040;
    step(5);
    chk("R7 lower half", dq_out, 32'h0000_3344);
    bus32 = 1;
    addr_pin = 22'h00_0041;
    step(5);
    chk("R7 x32 bit0 ignored", rd_addr, 22'h00_0040);

    // R3 busy forces status
    pe_busy = 1; status_in = 8'h5A;
    step(1);
    chk("R3 busy status", dq_out, 32'h0000_005A);
    chk("R10 busy not ready", ready, 0);
    pe_busy = 0; status_in = 8'h80;

    // R1 bus off
    oe_n = 1;
    step(3);
    chk("R1 oe high", {dq_oe, dq_out}, 33'h0);
    oe_n = 0; ce_n = 1;
    step(3);
    chk("R1 ce high", {dq_oe, dq_out}, 33'h0);
    ce_n = 0;
    step(3);
    pd_n = 0;
    step(3);
    chk("R1 pd low", dq_oe, 0);
    pd_n = 1;
    step(WD + 6);
    ce_n = 1; oe_n = 1;

    // R8 reset pin: mode cleared, writes blocked; R9 no abort when idle
    mode_sel = 2; mode_ld = 1; step(1); mode_ld = 0; step(1);
    pd_n = 0;
    step(3);
    chk("R8 status_clr", status_clr, 1);
    chk("R9 no abort when idle", aborts, 0);
    wr_we(22'h00_0500, 32'h0000_0001, '0, '0, 0);
    pd_n = 1;
    step(WD + 6);
    chk("R8 status_clr released", status_clr, 0);
    chk("R8 mode back to array", rd_mode, 0);
    ce_n = 0; oe_n = 0;
    step(5);
    chk("R8 array read after reset", dq_out, 32'h1122_3344);
    ce_n = 1; oe_n = 1;

    // R9 abort while busy
    pe_busy = 1;
    pd_n = 0;
    step(4);
    chk("R9 one abort pulse", aborts, 1);
    pe_busy = 0;

    // R10 holdoff after release
    pd_n = 1;
    step(3);
    chk("R10 ready low in holdoff", ready, 0);
    wr_we(22'h00_0600, 32'h0000_0002, '0, '0, 0);
    step(WD);
    chk("R10 ready after holdoff", ready, 1);
    wr_we(22'h00_0700, 32'h0000_0003, 22'h00_0700, 32'h0000_0003, 1);

    step(10);
    chk("R6 all strobes seen", q_cyc.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule